// File: doc/BRIEF.md
# Dual-Domain Interrupt Aggregator

This block gathers up to 64 interrupt inputs into two 32-bit banks and latches each input as a pending bit. With the default parameters, 49 inputs are present. A per-bit steering register decides where each input's pending bit lands. It goes either to the user domain or to the system domain. Each domain has its own enable word, its own force-set (preset) word, its own write-one-to-clear word and its own pending-status word.

The user domain drives one output line per source. Each line is the AND of that source's user pending bit and its user enable bit. The system domain drives a single combined line, which is high whenever any system pending bit is also enabled. Software reaches all of this through a flat 32-bit register port with byte addresses that step by 4. Writes take effect on the clock edge. Reads are combinational from the address.

One source index is reserved, and indices at or above the source count are unpopulated. Every register bit belonging to such an index stays at zero.

Top module: `dual_domain_intc`

## Requirements
- R1: After reset, every register reads 0 and every output is low.
- R2: A rising edge on a source input sets that source's pending bit in one domain only. The domain is user when the source's steering bit is 1 and system when it is 0. The other domain's pending bit is left unchanged.
- R3: Output line i of `user_irq_o` is high exactly when user pending bit i and user enable bit i are both 1. It follows the registers with no added delay.
- R4: `sys_irq_o` is high exactly when at least one bit is set in both the system pending word and the system enable word.
- R5: Writing a 1 to a bit of a clear word drops that pending bit. Bits written as 0 keep their value.
- R6: Writing a 1 to a bit of a preset word sets that pending bit. Bits written as 0 keep their value.
- R7: If a source edge and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R8: Preset and clear words read as 0. Writes to the status words are ignored. Unmapped or misaligned addresses read 0 and take no write.
- R9: Reserved source 35 and indices 49..63 read 0 in every register and never raise an output.
- R10: Bank b (0 or 1) lives at these byte addresses: steering 0x08+4b, system enable 0x10+4b, system preset 0x18+4b, system clear 0x20+4b, system status 0x28+4b, user enable 0x40+4b, user preset 0x48+4b, user clear 0x50+4b, user status 0x58+4b. Source i is bit i%32 of bank i/32.
- R11: A source that stays high sets its pending bit once per rising edge. If that bit is cleared while the input is still high, it stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| user_irq_o | output | NUM_SRC | Per-source user-domain interrupt lines |
| sys_irq_o | output | 1 | Combined system-domain interrupt |

## Verification
Single-source pulses are applied with every source steered to the user side. They are then repeated with one source steered to the system side, which shows whether the steering bit picks the domain and leaves the other domain alone. A source held high across a clear shows whether the block latches edges or levels. An edge that arrives in the same cycle as a clear of the same bit exposes which of the two takes priority. Finally, every input is driven high at once while writes land on the reserved and unpopulated positions, to confirm those bits stay dead in every register and on every output.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int WORD_W = 32;

    // Register group offsets; bit 2 of the address picks the bank.
    localparam logic [7:0] OFF_STEER = 8'h08;
    localparam logic [7:0] OFF_SEN   = 8'h10;
    localparam logic [7:0] OFF_SPRE  = 8'h18;
    localparam logic [7:0] OFF_SCLR  = 8'h20;
    localparam logic [7:0] OFF_SST   = 8'h28;
    localparam logic [7:0] OFF_UEN   = 8'h40;
    localparam logic [7:0] OFF_UPRE  = 8'h48;
    localparam logic [7:0] OFF_UCLR  = 8'h50;
    localparam logic [7:0] OFF_UST   = 8'h58;

    typedef struct packed {
        logic steer;
        logic sen;
        logic spre;
        logic sclr;
        logic uen;
        logic upre;
        logic uclr;
    } bank_wr_t;

endpackage

// File: rtl/intc_src_detect.sv
module intc_src_detect #(
    parameter int N         = 49,
    parameter bit EDGE_TRIG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] ev_o
);

    generate
        if (EDGE_TRIG) begin : g_edge
            logic [N-1:0] prev_d, prev_q;

            always_comb begin
                prev_d = src_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= prev_d;
            end

            assign ev_o = src_i & ~prev_q;
        end else begin : g_level
            assign ev_o = src_i;
        end
    endgenerate

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] wdata_i,
    input  bank_wr_t     we_i,
    output logic [W-1:0] steer_o,
    output logic [W-1:0] sen_o,
    output logic [W-1:0] sst_o,
    output logic [W-1:0] uen_o,
    output logic [W-1:0] ust_o
);

    typedef struct packed {
        logic [W-1:0] steer;
        logic [W-1:0] sen;
        logic [W-1:0] sst;
        logic [W-1:0] uen;
        logic [W-1:0] ust;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        logic [W-1:0] s_clr, s_set, u_clr, u_set;
        st_d  = st_q;
        s_clr = we_i.sclr ? wdata_i : '0;
        u_clr = we_i.uclr ? wdata_i : '0;
        // Event is routed by the steering word currently held.
        s_set = (ev_i & ~st_q.steer) | (we_i.spre ? wdata_i : '0);
        u_set = (ev_i &  st_q.steer) | (we_i.upre ? wdata_i : '0);

        if (we_i.steer) st_d.steer = wdata_i & VALID;
        if (we_i.sen)   st_d.sen   = wdata_i & VALID;
        if (we_i.uen)   st_d.uen   = wdata_i & VALID;

        // Set is applied after clear so a coincident event survives.
        st_d.sst = ((st_q.sst & ~s_clr) | s_set) & VALID;
        st_d.ust = ((st_q.ust & ~u_clr) | u_set) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign steer_o = st_q.steer;
    assign sen_o   = st_q.sen;
    assign sst_o   = st_q.sst;
    assign uen_o   = st_q.uen;
    assign ust_o   = st_q.ust;

endmodule

// File: rtl/dual_domain_intc.sv
module dual_domain_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 49,
    parameter int RSVD_SRC  = 35,
    parameter bit EDGE_TRIG = 1'b1,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [NUM_SRC-1:0] user_irq_o,
    output logic               sys_irq_o
);

    localparam int NUM_BANK = 2;
    localparam int TOT      = NUM_BANK * DATA_W;

    function automatic logic [TOT-1:0] calc_valid();
        logic [TOT-1:0] v;
        for (int i = 0; i < TOT; i++) v[i] = (i < NUM_SRC) && (i != RSVD_SRC);
        return v;
    endfunction

    localparam logic [TOT-1:0] VALID = calc_valid();

    logic [NUM_SRC-1:0] ev_src;
    logic [TOT-1:0]     ev_all;
    logic [TOT-1:0]     steer_all, sen_all, sst_all, uen_all, ust_all;

    intc_src_detect #(.N(NUM_SRC), .EDGE_TRIG(EDGE_TRIG)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .ev_o  (ev_src)
    );

    assign ev_all = {{(TOT-NUM_SRC){1'b0}}, ev_src} & VALID;

    // Address decode: group offset, bank select, alignment.
    logic [ADDR_W-1:0] grp;
    logic              bsel;
    logic              aligned;

    assign grp     = {addr_i[ADDR_W-1:3], 3'b000};
    assign bsel    = addr_i[2];
    assign aligned = (addr_i[1:0] == 2'b00);

    generate
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            bank_wr_t we;
            logic     hit;

            assign hit      = wr_en_i && aligned && (bsel == 1'(b));
            assign we.steer = hit && (grp == ADDR_W'(OFF_STEER));
            assign we.sen   = hit && (grp == ADDR_W'(OFF_SEN));
            assign we.spre  = hit && (grp == ADDR_W'(OFF_SPRE));
            assign we.sclr  = hit && (grp == ADDR_W'(OFF_SCLR));
            assign we.uen   = hit && (grp == ADDR_W'(OFF_UEN));
            assign we.upre  = hit && (grp == ADDR_W'(OFF_UPRE));
            assign we.uclr  = hit && (grp == ADDR_W'(OFF_UCLR));

            intc_bank #(.W(DATA_W), .VALID(VALID[b*DATA_W +: DATA_W])) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .ev_i    (ev_all[b*DATA_W +: DATA_W]),
                .wdata_i (wdata_i),
                .we_i    (we),
                .steer_o (steer_all[b*DATA_W +: DATA_W]),
                .sen_o   (sen_all[b*DATA_W +: DATA_W]),
                .sst_o   (sst_all[b*DATA_W +: DATA_W]),
                .uen_o   (uen_all[b*DATA_W +: DATA_W]),
                .ust_o   (ust_all[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    // Read path: preset/clear and unmapped words return zero.
    always_comb begin
        int base;
        base    = bsel ? DATA_W : 0;
        rdata_o = '0;
        if (aligned) begin
            if      (grp == ADDR_W'(OFF_STEER)) rdata_o = steer_all[base +: DATA_W];
            else if (grp == ADDR_W'(OFF_SEN))   rdata_o = sen_all[base +: DATA_W];
            else if (grp == ADDR_W'(OFF_SST))   rdata_o = sst_all[base +: DATA_W];
            else if (grp == ADDR_W'(OFF_UEN))   rdata_o = uen_all[base +: DATA_W];
            else if (grp == ADDR_W'(OFF_UST))   rdata_o = ust_all[base +: DATA_W];
        end
    end

    logic [TOT-1:0] user_act;
    assign user_act   = ust_all & uen_all;
    assign user_irq_o = user_act[NUM_SRC-1:0];
    assign sys_irq_o  = |(sst_all & sen_all);

endmodule

// File: rtl/dual_domain_intc_chk.sv
module dual_domain_intc_chk #(
    parameter int NUM_SRC  = 49,
    parameter int RSVD_SRC = 35,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int TOT      = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [TOT-1:0]    ust_all,
    input logic [TOT-1:0]    ev_all
);

    // R9
    dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ust_all[RSVD_SRC] == 1'b0) && ((ust_all >> NUM_SRC) == '0));

    // R6
    preset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(8'h48))
        |=> ((ust_all[DATA_W-1:0] & $past(wdata_i)) == $past(wdata_i)));

    // R5
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(8'h50))
        |=> ((ust_all[DATA_W-1:0] & $past(wdata_i) & ~$past(ev_all[DATA_W-1:0])) == '0));

    // R8
    wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(8'h18) || addr_i == ADDR_W'(8'h24) ||
         addr_i == ADDR_W'(8'h4C) || addr_i == ADDR_W'(8'h50)) |-> (rdata_o == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && ev_all == '0) |=> $stable(ust_all));

endmodule

bind dual_domain_intc dual_domain_intc_chk #(
    .NUM_SRC (NUM_SRC),
    .RSVD_SRC(RSVD_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TOT     (TOT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ust_all (ust_all),
    .ev_all  (ev_all)
);

// File: tb/tb_dual_domain_intc.sv
`timescale 1ns/1ps
module tb_dual_domain_intc;

    localparam int NS = 49;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NS-1:0] user_irq;
    logic          sys_irq;

    int errs = 0;
    int checks = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    dual_domain_intc dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .user_irq_o(user_irq), .sys_irq_o(sys_irq)
    );

    // Behavioural reference model
    logic [63:0] m_steer, m_sen, m_sst, m_uen, m_ust, m_prev;

    function automatic bit has_src(int i);
        return (i < NS) && (i != 35);
    endfunction

    always @(posedge clk) begin
        logic [63:0] n_steer, n_sen, n_sst, n_uen, n_ust, sx;
        if (!rst_n) begin
            m_steer = '0; m_sen = '0; m_sst = '0; m_uen = '0; m_ust = '0; m_prev = '0;
        end else begin
            sx = {15'b0, src};
            n_steer = m_steer; n_sen = m_sen; n_sst = m_sst; n_uen = m_uen; n_ust = m_ust;
            for (int i = 0; i < 64; i++) begin
                int  b;
                bit  w, ev;
                b  = i / 32;
                w  = wr_en && wdata[i % 32];
                ev = sx[i] && !m_prev[i];
                if (has_src(i)) begin
                    if (addr == 8'(8'h08 + 4*b)) n_steer[i] = w ? 1'b1 : (wr_en ? 1'b0 : m_steer[i]);
                    if (addr == 8'(8'h10 + 4*b)) n_sen[i]   = w ? 1'b1 : (wr_en ? 1'b0 : m_sen[i]);
                    if (addr == 8'(8'h40 + 4*b)) n_uen[i]   = w ? 1'b1 : (wr_en ? 1'b0 : m_uen[i]);
                    if (w && addr == 8'(8'h20 + 4*b)) n_sst[i] = 1'b0;
                    if (w && addr == 8'(8'h50 + 4*b)) n_ust[i] = 1'b0;
                    if (w && addr == 8'(8'h18 + 4*b)) n_sst[i] = 1'b1;
                    if (w && addr == 8'(8'h48 + 4*b)) n_ust[i] = 1'b1;
                    if (ev &&  m_steer[i]) n_ust[i] = 1'b1;
                    if (ev && !m_steer[i]) n_sst[i] = 1'b1;
                end
            end
            m_steer = n_steer; m_sen = n_sen; m_sst = n_sst; m_uen = n_uen; m_ust = n_ust;
            m_prev = sx;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h08: return m_steer[31:0];  8'h0C: return m_steer[63:32];
            8'h10: return m_sen[31:0];    8'h14: return m_sen[63:32];
            8'h28: return m_sst[31:0];    8'h2C: return m_sst[63:32];
            8'h40: return m_uen[31:0];    8'h44: return m_uen[63:32];
            8'h58: return m_ust[31:0];    8'h5C: return m_ust[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock output comparison (R3, R4)
    always @(negedge clk) begin
        if (live) begin
            logic [63:0] ua;
            ua = m_ust & m_uen;
            check("R3 user lines", {15'b0, user_irq}, {15'b0, ua[NS-1:0]});
            check("R4 sys line", {63'b0, sys_irq}, {63'b0, |(m_sst & m_sen)});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(string req, logic [7:0] a);
        @(negedge clk);
        addr = a;
        #2;
        check(req, {32'b0, rdata}, {32'b0, m_read(a)});
    endtask

    task automatic rd_lit(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #2;
        check(req, {32'b0, rdata}, {32'b0, exp});
    endtask

    task automatic pulse(int i);
        @(negedge clk); src[i] = 1'b1;
        @(negedge clk); src[i] = 1'b0;
    endtask

    initial begin
        #4000000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state over every word of the map (R10)
        for (int a = 0; a < 8'h60; a += 4) rd_lit("R1 reset read", 8'(a), 32'h0);
        check("R1 reset outputs", {14'b0, user_irq, sys_irq}, 64'h0);

        // R9 steering writes on unpopulated bits
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_lit("R9 steer bank1", 8'h0C, 32'h0001_FFF7);
        rd("R10 steer bank0", 8'h08);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd_lit("R9 uen bank1", 8'h44, 32'h0001_FFF7);

        // R2 user-steered pulses
        pulse(0); pulse(5); pulse(40);
        rd_lit("R2 user status b0", 8'h58, 32'h0000_0021);
        rd_lit("R2 user status b1", 8'h5C, 32'h0000_0100);
        rd_lit("R2 sys untouched", 8'h28, 32'h0);

        // R5 clear
        wr(8'h50, 32'h0000_0001);
        rd_lit("R5 clear one bit", 8'h58, 32'h0000_0020);

        // R2/R4 system steering
        wr(8'h08, 32'hFFFF_FF7F);
        wr(8'h10, 32'h0000_0080);
        pulse(7);
        rd_lit("R2 sys status", 8'h28, 32'h0000_0080);
        rd_lit("R2 user side clear", 8'h58, 32'h0000_0020);
        @(negedge clk);
        check("R4 sys line high", {63'b0, sys_irq}, 64'h1);
        wr(8'h20, 32'h0000_0080);
        rd_lit("R5 sys clear", 8'h28, 32'h0);

        // R6 preset, R9 reserved bit
        wr(8'h4C, 32'h0000_000C);
        rd_lit("R6 R9 preset", 8'h5C, 32'h0000_0104);
        wr(8'h18, 32'h0000_1000);
        rd_lit("R6 sys preset", 8'h28, 32'h0000_1000);
        rd_lit("R8 preset reads 0", 8'h48, 32'h0);
        rd_lit("R8 clear reads 0", 8'h24, 32'h0);

        // R8 status write ignored, unmapped
        wr(8'h58, 32'h0);
        rd_lit("R8 status ro", 8'h58, 32'h0000_0020);
        wr(8'h30, 32'hFFFF_FFFF);
        rd_lit("R8 unmapped", 8'h30, 32'h0);
        rd_lit("R8 misaligned", 8'h59, 32'h0);

        // R7 edge and clear same cycle
        @(negedge clk);
        src[10] = 1'b1; wr_en = 1'b1; addr = 8'h50; wdata = 32'h0000_0400;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0; src[10] = 1'b0;
        rd_lit("R7 set wins", 8'h58, 32'h0000_0420);

        // R11 held-high source
        @(negedge clk); src[12] = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h50, 32'h0000_1000);
        repeat (3) @(negedge clk);
        rd_lit("R11 held level", 8'h58, 32'h0000_0420);
        src[12] = 1'b0;

        // R9 all inputs high
        @(negedge clk); src = '1;
        repeat (2) @(negedge clk);
        rd_lit("R9 all high b1", 8'h5C, 32'h0001_FFF7);
        check("R9 line 35", {63'b0, user_irq[35]}, 64'h0);
        rd("R2 all high b0", 8'h58);
        rd("R2 all high sys", 8'h28);
        src = '0;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule